// File: doc/BRIEF.md
# Virtual Interrupt Priority Mask Filter

This block keeps the priority threshold of one virtual CPU interface and uses it to decide whether a pending virtual interrupt is forwarded to the processing element. A lower numeric priority means a more urgent interrupt. An interrupt passes only when its priority value is strictly below the stored threshold.

The threshold has two views. The guest sees it in the low byte of a 32-bit word at offset 0x004 of its register window. Guest reads return data one cycle after the strobe. The hypervisor sees the same storage as an 8-bit field of its virtual machine control word, at a bit position set by a parameter. Both views use one set of flops, so a write through either view is visible through the other on the next cycle.

A parameter sets how many priority levels exist (16, 32, 64, 128 or 256). The low bits of the threshold that those levels do not use read as zero and ignore writes. The same low bits are cleared in the incoming priority before the comparison. The threshold resets to zero, which blocks everything, but software should treat the value after reset as undefined.

Top module: `vprio_mask_filter`

## Requirements
- R1: A guest read strobe at offset 0x004 returns, in the following cycle, the threshold in g_rdata[7:0] with g_rdata[31:8] zero. The value returned is the one held before any write made in the same cycle.
- R2: A guest read strobe at any offset other than 0x004 returns zero in the following cycle.
- R3: With L priority levels, the lowest 8-log2(L) threshold bits always read as zero through both views, and writes to those bits are ignored.
- R4: hv_rdata carries the threshold in bits [HV_MASK_LSB+7:HV_MASK_LSB] and zero in all other bits. A hypervisor write loads the threshold from those same bits and ignores the rest of hv_wdata.
- R5: A guest write at 0x004 is visible in hv_rdata on the next cycle. A hypervisor write is returned by a guest read strobed on the next cycle.
- R6: When the guest (at 0x004) and the hypervisor write in the same cycle, the hypervisor value is stored.
- R7: irq_signal is high exactly when irq_valid is high and irq_prio, with its unimplemented low bits cleared, is strictly less than the threshold. A new threshold applies from the cycle after the write.
- R8: irq_signal is low whenever irq_valid is low.
- R9: Guest writes at any offset other than 0x004 leave the threshold unchanged.
- R10: g_rdata is zero after reset and keeps its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| g_wr_en | input | 1 | Guest write strobe |
| g_rd_en | input | 1 | Guest read strobe |
| g_addr | input | ADDR_W | Guest byte offset |
| g_wdata | input | 32 | Guest write data |
| g_rdata | output | 32 | Guest read data, registered |
| hv_wr_en | input | 1 | Hypervisor control word write strobe |
| hv_wdata | input | 32 | Hypervisor control word write data |
| hv_rdata | output | 32 | Hypervisor view of the threshold field |
| irq_valid | input | 1 | Pending virtual interrupt present |
| irq_prio | input | 8 | Priority of the pending interrupt |
| irq_signal | output | 1 | Forward the interrupt to the processing element |

## Verification
The bench builds two copies that share all inputs. The default copy has 32 levels with the hypervisor field at bit 24. This makes three dead low bits and a field in the top byte, so masked writes and the alias shift can both be tested. The second copy has 256 levels with the field at bit 16. In this copy every bit is live, so the equality case of the strict compare can be reached at odd values. Random traffic mixes overlapping writes from both views, off-offset accesses and boundary priorities around the current threshold, and both copies are checked against one reference model.

// File: rtl/vpmf_pkg.sv
package vpmf_pkg;
   localparam int unsigned PRIO_W = 8;
   localparam int unsigned WORD_W = 32;

   function automatic bit levels_legal(int unsigned levels);
      return (levels == 16) || (levels == 32) || (levels == 64) ||
             (levels == 128) || (levels == 256);
   endfunction

   // Count of low threshold bits that are not implemented.
   function automatic int unsigned dead_bits(int unsigned levels);
      return PRIO_W - $clog2(levels);
   endfunction

   function automatic logic [PRIO_W-1:0] live_mask(int unsigned levels);
      logic [PRIO_W-1:0] m;
      m = '1;
      return m << dead_bits(levels);
   endfunction
endpackage

// File: rtl/vpmf_mask_store.sv
module vpmf_mask_store
   import vpmf_pkg::*;
#(
   parameter int unsigned PRIO_LEVELS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              g_we,
   input  logic [PRIO_W-1:0] g_wval,
   input  logic              h_we,
   input  logic [PRIO_W-1:0] h_wval,
   output logic [PRIO_W-1:0] mask_q
);
   localparam int unsigned LO = dead_bits(PRIO_LEVELS);

   for (genvar b = 0; b < PRIO_W; b++) begin : g_bit
      if (b >= LO) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    mask_q[b] <= 1'b0;
            else if (h_we) mask_q[b] <= h_wval[b];
            else if (g_we) mask_q[b] <= g_wval[b];
         end
      end else begin : g_dead
         assign mask_q[b] = 1'b0;
      end
   end

   logic unused_dead_inputs;
   assign unused_dead_inputs = ^{g_wval, h_wval};
endmodule

// File: rtl/vpmf_guest_port.sv
module vpmf_guest_port
   import vpmf_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter logic [ADDR_W-1:0] OFFSET = 'h4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [PRIO_W-1:0] mask_q,
   output logic              wr_hit,
   output logic [WORD_W-1:0] rdata
);
   logic hit;
   assign hit    = (addr == OFFSET);
   assign wr_hit = wr_en && hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= hit ? {{(WORD_W-PRIO_W){1'b0}}, mask_q} : '0;
   end
endmodule

// File: rtl/vpmf_hv_view.sv
module vpmf_hv_view
   import vpmf_pkg::*;
#(
   parameter int unsigned HV_MASK_LSB = 24
) (
   input  logic [PRIO_W-1:0] mask_q,
   input  logic [WORD_W-1:0] hv_wdata,
   output logic [PRIO_W-1:0] h_wval,
   output logic [WORD_W-1:0] hv_rdata
);
   assign h_wval = hv_wdata[HV_MASK_LSB +: PRIO_W];

   for (genvar i = 0; i < WORD_W; i++) begin : g_pos
      if (i >= HV_MASK_LSB && i < HV_MASK_LSB + PRIO_W) begin : g_field
         assign hv_rdata[i] = mask_q[i-HV_MASK_LSB];
      end else begin : g_zero
         assign hv_rdata[i] = 1'b0;
      end
   end

   logic unused_other_fields;
   assign unused_other_fields = ^hv_wdata;
endmodule

// File: rtl/vpmf_prio_filter.sv
module vpmf_prio_filter
   import vpmf_pkg::*;
#(
   parameter int unsigned PRIO_LEVELS = 32
) (
   input  logic              irq_valid,
   input  logic [PRIO_W-1:0] irq_prio,
   input  logic [PRIO_W-1:0] mask_q,
   output logic              irq_signal
);
   localparam logic [PRIO_W-1:0] LIVE = live_mask(PRIO_LEVELS);
   logic [PRIO_W-1:0] prio_eff;

   assign prio_eff   = irq_prio & LIVE;
   assign irq_signal = irq_valid && (prio_eff < mask_q);
endmodule

// File: rtl/vprio_mask_filter.sv
module vprio_mask_filter
   import vpmf_pkg::*;
#(
   parameter int unsigned PRIO_LEVELS  = 32,
   parameter int unsigned HV_MASK_LSB  = 24,
   parameter int unsigned ADDR_W       = 12,
   parameter logic [ADDR_W-1:0] GUEST_OFFSET = 'h4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              g_wr_en,
   input  logic              g_rd_en,
   input  logic [ADDR_W-1:0] g_addr,
   input  logic [31:0]       g_wdata,
   output logic [31:0]       g_rdata,
   input  logic              hv_wr_en,
   input  logic [31:0]       hv_wdata,
   output logic [31:0]       hv_rdata,
   input  logic              irq_valid,
   input  logic [7:0]        irq_prio,
   output logic              irq_signal
);
   if (!levels_legal(PRIO_LEVELS)) begin : g_bad_levels
      $error("PRIO_LEVELS must be 16, 32, 64, 128 or 256");
   end
   if (HV_MASK_LSB + PRIO_W > WORD_W) begin : g_bad_lsb
      $error("HV_MASK_LSB places the field outside the word");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W too narrow for the guest offset");
   end

   logic [PRIO_W-1:0] mask_q;
   logic [PRIO_W-1:0] h_wval;
   logic              g_hit;

   vpmf_guest_port #(.ADDR_W(ADDR_W), .OFFSET(GUEST_OFFSET)) u_guest (
      .clk(clk), .rst_n(rst_n), .wr_en(g_wr_en), .rd_en(g_rd_en),
      .addr(g_addr), .mask_q(mask_q), .wr_hit(g_hit), .rdata(g_rdata)
   );

   vpmf_hv_view #(.HV_MASK_LSB(HV_MASK_LSB)) u_hv (
      .mask_q(mask_q), .hv_wdata(hv_wdata), .h_wval(h_wval), .hv_rdata(hv_rdata)
   );

   vpmf_mask_store #(.PRIO_LEVELS(PRIO_LEVELS)) u_store (
      .clk(clk), .rst_n(rst_n), .g_we(g_hit), .g_wval(g_wdata[PRIO_W-1:0]),
      .h_we(hv_wr_en), .h_wval(h_wval), .mask_q(mask_q)
   );

   vpmf_prio_filter #(.PRIO_LEVELS(PRIO_LEVELS)) u_filter (
      .irq_valid(irq_valid), .irq_prio(irq_prio), .mask_q(mask_q),
      .irq_signal(irq_signal)
   );

   logic unused_upper_wdata;
   assign unused_upper_wdata = ^g_wdata[WORD_W-1:PRIO_W];
endmodule

// File: rtl/vpmf_checker.sv
module vpmf_checker
   import vpmf_pkg::*;
#(
   parameter int unsigned PRIO_LEVELS  = 32,
   parameter int unsigned HV_MASK_LSB  = 24,
   parameter int unsigned ADDR_W       = 12,
   parameter logic [ADDR_W-1:0] GUEST_OFFSET = 'h4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              g_wr_en,
   input logic              g_rd_en,
   input logic [ADDR_W-1:0] g_addr,
   input logic [31:0]       g_wdata,
   input logic [31:0]       g_rdata,
   input logic              hv_wr_en,
   input logic [31:0]       hv_wdata,
   input logic [31:0]       hv_rdata,
   input logic              irq_valid,
   input logic [7:0]        irq_prio,
   input logic              irq_signal
);
   localparam logic [7:0]  LIVE  = live_mask(PRIO_LEVELS);
   localparam logic [31:0] FIELD = 32'hFF << HV_MASK_LSB;

   logic [7:0] fld;
   assign fld = hv_rdata[HV_MASK_LSB +: 8];

   a_r8_quiet_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_valid |-> !irq_signal);
   a_r7_strict_block: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && ((irq_prio & LIVE) >= fld)) |-> !irq_signal);
   a_r7_pass_below: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && ((irq_prio & LIVE) < fld)) |-> irq_signal);
   a_r3_dead_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (fld & ~LIVE) == 8'h00);
   a_r4_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (hv_rdata & ~FIELD) == 32'h0);
   a_r6_hv_wins: assert property (@(posedge clk) disable iff (!rst_n)
      hv_wr_en |=> fld == ($past(hv_wdata[HV_MASK_LSB +: 8]) & LIVE));
   a_r5_guest_to_hv: assert property (@(posedge clk) disable iff (!rst_n)
      (g_wr_en && g_addr == GUEST_OFFSET && !hv_wr_en) |=> fld == ($past(g_wdata[7:0]) & LIVE));
   a_r9_miss_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (g_wr_en && g_addr != GUEST_OFFSET && !hv_wr_en) |=> $stable(fld));
   a_r2_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (g_rd_en && g_addr != GUEST_OFFSET) |=> g_rdata == 32'h0);
   a_r1_hit_read: assert property (@(posedge clk) disable iff (!rst_n)
      (g_rd_en && g_addr == GUEST_OFFSET) |=> g_rdata == {24'h0, $past(fld)});
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !g_rd_en |=> $stable(g_rdata));

   logic unused_chk;
   assign unused_chk = ^{g_wdata[31:8], hv_wdata & ~FIELD};
endmodule

bind vprio_mask_filter vpmf_checker #(
   .PRIO_LEVELS(PRIO_LEVELS), .HV_MASK_LSB(HV_MASK_LSB),
   .ADDR_W(ADDR_W), .GUEST_OFFSET(GUEST_OFFSET)
) u_chk (.*);

// File: tb/vprio_mask_filter_bench.sv
module vprio_mask_filter_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        g_wr_en = 0, g_rd_en = 0, hv_wr_en = 0, irq_valid = 0;
   logic [11:0] g_addr = '0;
   logic [31:0] g_wdata = '0, hv_wdata = '0;
   logic [7:0]  irq_prio = '0;
   logic [31:0] rd_a, rd_b, hv_a, hv_b;
   logic        sig_a, sig_b;

   vprio_mask_filter u_vprio_mask_filter (
      .clk(clk), .rst_n(rst_n), .g_wr_en(g_wr_en), .g_rd_en(g_rd_en),
      .g_addr(g_addr), .g_wdata(g_wdata), .g_rdata(rd_a),
      .hv_wr_en(hv_wr_en), .hv_wdata(hv_wdata), .hv_rdata(hv_a),
      .irq_valid(irq_valid), .irq_prio(irq_prio), .irq_signal(sig_a));

   vprio_mask_filter #(.PRIO_LEVELS(256), .HV_MASK_LSB(16)) u_vprio_mask_filter_full (
      .clk(clk), .rst_n(rst_n), .g_wr_en(g_wr_en), .g_rd_en(g_rd_en),
      .g_addr(g_addr), .g_wdata(g_wdata), .g_rdata(rd_b),
      .hv_wr_en(hv_wr_en), .hv_wdata(hv_wdata), .hv_rdata(hv_b),
      .irq_valid(irq_valid), .irq_prio(irq_prio), .irq_signal(sig_b));

   int checks = 0, fails = 0;
   logic [7:0]  mdl   [2];
   bit          known [2];
   logic [31:0] last_rd [2];
   bit          rd_known [2];
   localparam logic [7:0] LIVE [2] = '{8'hF8, 8'hFF};
   localparam int         LSB  [2] = '{24, 16};

   task automatic chk(string req, string note, int k, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s (%s) inst%0d: actual %h expected %h", req, note, k, act, exp);
      end
   endtask

   // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
   task automatic step(string note, bit gw, bit gr, logic [11:0] ga, logic [31:0] gd,
                       bit hw, logic [31:0] hd, bit iv, logic [7:0] ip);
      logic [31:0] exp_rd [2];
      bit          rd_ok  [2];
      g_wr_en = gw; g_rd_en = gr; g_addr = ga; g_wdata = gd;
      hv_wr_en = hw; hv_wdata = hd; irq_valid = iv; irq_prio = ip;
      for (int k = 0; k < 2; k++) begin
         rd_ok[k] = 1;
         if (gr) begin
            if (ga == 12'h004) begin
               exp_rd[k] = {24'h0, mdl[k]};
               rd_ok[k]  = known[k];
            end else exp_rd[k] = 32'h0;
         end else begin
            exp_rd[k] = last_rd[k];
            rd_ok[k]  = rd_known[k];
         end
         rd_known[k] = rd_ok[k];
         last_rd[k]  = exp_rd[k];
         if (hw) begin
            mdl[k] = hd[LSB[k] +: 8] & LIVE[k]; known[k] = 1;
         end else if (gw && ga == 12'h004) begin
            mdl[k] = gd[7:0] & LIVE[k]; known[k] = 1;
         end
      end
      @(posedge clk);
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
         logic [31:0] ard, ahv;
         logic        asig;
         ard  = (k == 0) ? rd_a : rd_b;
         ahv  = (k == 0) ? hv_a : hv_b;
         asig = (k == 0) ? sig_a : sig_b;
         if (rd_ok[k])
            chk(gr ? ((ga == 12'h004) ? "R1" : "R2") : "R10", note, k, ard, exp_rd[k]);
         if (!iv) chk("R8", note, k, {31'h0, asig}, 32'h0);
         if (known[k]) begin
            chk("R4", note, k, ahv, {24'h0, mdl[k]} << LSB[k]);
            if (iv) chk("R7", note, k, {31'h0, asig},
                        {31'h0, ((ip & LIVE[k]) < mdl[k])});
         end
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5eed_1234));
      for (int k = 0; k < 2; k++) begin
         known[k] = 0; mdl[k] = '0; last_rd[k] = '0; rd_known[k] = 1;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state of the read register
      chk("R10", "reset", 0, rd_a, 32'h0);
      chk("R10", "reset", 1, rd_b, 32'h0);
      // R3: all ones written, dead bits come back zero
      step("R3 write ff", 1, 0, 12'h004, 32'hFFFF_FFFF, 0, 0, 0, 0);
      step("R3 read back", 0, 1, 12'h004, 0, 0, 0, 1, 8'hF7);
      // R7: equality and one-below around the threshold
      step("R7 equal", 0, 0, 0, 0, 0, 0, 1, 8'hF8);
      step("R7 equal full", 0, 0, 0, 0, 0, 0, 1, 8'hFF);
      step("R7 below", 0, 0, 0, 0, 0, 0, 1, 8'hFE);
      // R5: guest write seen by hypervisor, hypervisor write seen by guest
      step("R5 guest write", 1, 0, 12'h004, 32'h0000_0041, 0, 0, 1, 8'h40);
      step("R5 hv write", 0, 0, 0, 0, 1, 32'h2233_9900, 1, 8'h38);
      step("R5 guest read", 0, 1, 12'h004, 0, 0, 0, 1, 8'h10);
      // R6: both write together
      step("R6 collide", 1, 0, 12'h004, 32'h0000_00AA, 1, 32'h5511_5500, 1, 8'h50);
      step("R6 read", 0, 1, 12'h004, 0, 0, 0, 0, 0);
      // R9 and R2: other offsets
      step("R9 miss write", 1, 0, 12'h008, 32'h0000_0000, 0, 0, 1, 8'h00);
      step("R2 miss read", 0, 1, 12'h005, 0, 0, 0, 0, 0);
      // R4: noise outside the hypervisor field
      step("R4 noise", 0, 0, 0, 0, 1, 32'hA5C3_C35A, 0, 0);
      // R1: read returns value held before same-cycle write
      step("R1 rd+wr", 1, 1, 12'h004, 32'h0000_0080, 0, 0, 1, 8'h7F);
      step("R8 idle", 0, 0, 0, 0, 0, 0, 0, 8'h00);
      for (int n = 0; n < 4000; n++) begin
         bit gw, gr, hw, iv;
         logic [11:0] ga;
         logic [7:0]  ip;
         gw = ($urandom % 10) < 3;
         gr = ($urandom % 2) == 1;
         hw = ($urandom % 10) < 2;
         iv = ($urandom % 4) != 0;
         ga = (($urandom % 3) != 0) ? 12'h004 : 12'($urandom);
         case ($urandom % 4)
            0: ip = mdl[0];
            1: ip = mdl[1] - 8'd1;
            2: ip = mdl[1];
            default: ip = 8'($urandom);
         endcase
         step("random", gw, gr, ga, $urandom, hw, $urandom, iv, ip);
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule